// File: doc/BRIEF.md
# Printer-Port Expansion Bus Bridge

This block re-purposes the pins of a host printer port as a narrow expansion bus for an external adapter card. While the port is configured for adapter use, the host first writes the card's base address into a configuration byte. The bridge presents that byte on the port data pins with both adapter strobes pulled low together, so the card can capture its own address, and keeps a copy for decoding. After that, host I/O commands whose address falls inside the latched window become adapter read or write cycles. Each cycle carries the three low address bits and moves one data byte in either direction.

The decode window spans either 8 or 16 host ports, chosen by a granularity input. The bridge also forwards the adapter's interrupt and DMA request lines to the host, and the host's terminal count to the adapter, but only while the mode is active. All strobes and pin drives come from registers. A strobe asserts on the first clock edge that sees the host command and releases on the first clock edge after the command ends. The bus is paced by the host's command length, so there is no back-pressure at either edge. No valid/ready handshake exists.

Top module: `xb_bridge`

## Requirements
- R1: The mode is active only when `cfg_ext_dis` is 0 and `cfg_port_mode` equals 2'b10. When the mode is inactive, both strobes stay high, `pd_oe` stays low and `host_irq7`, `host_drq` and `xtc` are 0.
- R2: While `cfg_sel` is high and the mode is active, the clock edge that samples it drives `xrd_n` and `xwr_n` low together, sets `pd_oe` to 1 and puts `cfg_data` on `pd_out`. Both strobes return high on the first edge after `cfg_sel` falls.
- R3: The configuration byte holds host address bits 9:2 (byte bit k is address bit k+2). It is latched whenever `cfg_sel` is high. Reset clears it, and no adapter cycle occurs until it has been written at least once.
- R4: With `cfg_coarse` at 0, an address hits when host address bits 9:3 equal byte bits 7:1 (an 8-port window).
- R5: With `cfg_coarse` at 1, an address hits when host address bits 9:4 equal byte bits 7:2 (a 16-port window).
- R6: A hit with `host_aen` low and `host_ior_n` low gives a read cycle. In a read cycle `xrd_n` is low, `xwr_n` is high and `pd_oe` is 0. `host_rdata_oe` is 1 and `host_rdata` equals `pd_in`.
- R7: A hit with `host_aen` low and `host_iow_n` low gives a write cycle. In a write cycle `xwr_n` is low, `pd_oe` is 1 and `pd_out` holds `host_wdata`. If both commands are low, the write wins.
- R8: During an adapter cycle, `xa` holds host address bits 2:0 sampled on the edge that started the cycle.
- R9: A strobe is asserted on the edge after the command is seen and released on the edge after the command ends. No cycle starts while `host_aen` is high.
- R10: While the mode is active, `host_irq7` follows `xirq`, `host_drq` follows the active-high `xdrq`, and `xtc` follows `host_tc` unchanged.
- R11: A configuration write takes priority over a simultaneous adapter cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_dis | input | 1 | Adapter mode disable bit (0 allows the mode) |
| cfg_port_mode | input | 2 | Port mode field; 2'b10 selects adapter use |
| cfg_coarse | input | 1 | Window granularity: 0 = 8 ports, 1 = 16 ports |
| cfg_sel | input | 1 | Host write to the base-address byte in progress |
| cfg_data | input | 8 | Base-address byte (host address bits 9:2) |
| host_addr | input | 10 | Host I/O address |
| host_aen | input | 1 | Host address enable (high = DMA owns bus) |
| host_ior_n | input | 1 | Host I/O read command, active low |
| host_iow_n | input | 1 | Host I/O write command, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Byte captured from the adapter |
| host_rdata_oe | output | 1 | Host data bus drive enable for reads |
| host_tc | input | 1 | Host DMA terminal count |
| host_irq7 | output | 1 | Interrupt toward host line 7 |
| host_drq | output | 1 | DMA request toward host |
| xrd_n | output | 1 | Adapter read strobe, active low |
| xwr_n | output | 1 | Adapter write strobe, active low |
| xa | output | 3 | Adapter low address |
| pd_out | output | 8 | Data pins, output value |
| pd_oe | output | 1 | Data pins drive enable |
| pd_in | input | 8 | Data pins, input value |
| xirq | input | 1 | Adapter interrupt request |
| xdrq | input | 1 | Adapter DMA request, active high |
| xtc | output | 1 | Terminal count to adapter |

## Verification
The decode is swept over all 1024 host addresses against several base bytes, including all-zeros, all-ones and mixed patterns, in both granularities. This separates the bit 3 term that only the fine window compares from the bits 9:4 that both windows compare, and it exposes any off-by-one in the byte-to-address alignment. A read issued before any base write, at the address the reset value would match, tells whether the written-once rule holds. All eight configuration combinations show that only one mode code enables strobes and routing. Writes with distinct data patterns, an AEN-high command and an overlapping configuration write show the data direction, the DMA blocking and the priority.

// File: rtl/xb_pkg.sv
package xb_pkg;
  typedef enum logic [1:0] {
    XB_IDLE  = 2'd0,
    XB_BCAST = 2'd1,
    XB_READ  = 2'd2,
    XB_WRITE = 2'd3
  } xb_cyc_e;
endpackage

// File: rtl/xb_mode_gate.sv
module xb_mode_gate #(
  parameter logic [1:0] MODE_CODE = 2'b10
) (
  input  logic       cfg_ext_dis,
  input  logic [1:0] cfg_port_mode,
  input  logic       xirq,
  input  logic       xdrq,
  input  logic       host_tc,
  output logic       active,
  output logic       host_irq7,
  output logic       host_drq,
  output logic       xtc
);
  always_comb begin
    active    = !cfg_ext_dis && (cfg_port_mode == MODE_CODE);
    host_irq7 = active && xirq;
    host_drq  = active && xdrq;
    xtc       = active && host_tc;
  end
endmodule

// File: rtl/xb_window.sv
module xb_window #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int LOW_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_coarse,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              hit
);
  // byte bit k maps to host address bit k+BASE_LSB
  localparam int BASE_LSB = ADDR_W - DATA_W;

  logic [DATA_W-1:0]     base_q;
  logic                  valid_q;
  logic [ADDR_W-1:LOW_W] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else if (cfg_sel) begin
      base_q  <= cfg_data;
      valid_q <= 1'b1;
    end
  end

  for (genvar i = LOW_W; i < ADDR_W; i++) begin : g_cmp
    assign match[i] = (host_addr[i] == base_q[i-BASE_LSB]);
  end

  // bit LOW_W is the one term the coarse window drops
  assign hit = valid_q && (&match[ADDR_W-1:LOW_W+1]) && (cfg_coarse || match[LOW_W]);
endmodule

// File: rtl/xb_strobe.sv
module xb_strobe
  import xb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int LOW_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              hit,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              host_aen,
  input  logic              host_ior_n,
  input  logic              host_iow_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              xrd_n,
  output logic              xwr_n,
  output logic [LOW_W-1:0]  xa,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  output logic              rd_phase
);
  xb_cyc_e           cyc_d, cyc_q;
  logic [LOW_W-1:0]  xa_q;
  logic [DATA_W-1:0] pd_q;
  logic              cmd_ok;

  always_comb begin
    cmd_ok = hit && !host_aen;
    if (!active)                    cyc_d = XB_IDLE;
    else if (cfg_sel)               cyc_d = XB_BCAST;
    else if (cmd_ok && !host_iow_n) cyc_d = XB_WRITE;
    else if (cmd_ok && !host_ior_n) cyc_d = XB_READ;
    else                            cyc_d = XB_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= XB_IDLE;
      xa_q  <= '0;
      pd_q  <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (cyc_d == XB_READ || cyc_d == XB_WRITE) xa_q <= host_addr[LOW_W-1:0];
      if (cyc_d == XB_BCAST)      pd_q <= cfg_data;
      else if (cyc_d == XB_WRITE) pd_q <= host_wdata;
    end
  end

  assign xrd_n    = !(cyc_q == XB_BCAST || cyc_q == XB_READ);
  assign xwr_n    = !(cyc_q == XB_BCAST || cyc_q == XB_WRITE);
  assign pd_oe    = (cyc_q == XB_BCAST || cyc_q == XB_WRITE);
  assign rd_phase = (cyc_q == XB_READ);
  assign xa       = xa_q;
  assign pd_out   = pd_q;
endmodule

// File: rtl/xb_bridge.sv
module xb_bridge #(
  parameter int         ADDR_W    = 10,
  parameter int         DATA_W    = 8,
  parameter int         LOW_W     = 3,
  parameter logic [1:0] MODE_CODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_dis,
  input  logic [1:0]        cfg_port_mode,
  input  logic              cfg_coarse,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_aen,
  input  logic              host_ior_n,
  input  logic              host_iow_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic              host_tc,
  output logic              host_irq7,
  output logic              host_drq,
  output logic              xrd_n,
  output logic              xwr_n,
  output logic [LOW_W-1:0]  xa,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic [DATA_W-1:0] pd_in,
  input  logic              xirq,
  input  logic              xdrq,
  output logic              xtc
);
  logic active, hit, rd_phase;

  xb_mode_gate #(.MODE_CODE(MODE_CODE)) u_gate (
    .cfg_ext_dis(cfg_ext_dis), .cfg_port_mode(cfg_port_mode),
    .xirq(xirq), .xdrq(xdrq), .host_tc(host_tc),
    .active(active), .host_irq7(host_irq7), .host_drq(host_drq), .xtc(xtc)
  );

  xb_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_win (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cfg_coarse(cfg_coarse), .host_addr(host_addr), .hit(hit)
  );

  xb_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .active(active), .hit(hit),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .host_aen(host_aen),
    .host_ior_n(host_ior_n), .host_iow_n(host_iow_n), .host_addr(host_addr),
    .host_wdata(host_wdata), .xrd_n(xrd_n), .xwr_n(xwr_n), .xa(xa),
    .pd_out(pd_out), .pd_oe(pd_oe), .rd_phase(rd_phase)
  );

  assign host_rdata_oe = rd_phase;
  assign host_rdata    = rd_phase ? pd_in : '0;
endmodule

// File: rtl/xb_bridge_chk.sv
module xb_bridge_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int LOW_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ext_dis,
  input logic [1:0]        cfg_port_mode,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_aen,
  input logic              host_ior_n,
  input logic              host_iow_n,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdata_oe,
  input logic              host_tc,
  input logic              host_irq7,
  input logic              host_drq,
  input logic              xrd_n,
  input logic              xwr_n,
  input logic [LOW_W-1:0]  xa,
  input logic              pd_oe,
  input logic [DATA_W-1:0] pd_in,
  input logic              xirq,
  input logic              xdrq,
  input logic              xtc
);
  logic mode_on;
  assign mode_on = !cfg_ext_dis && (cfg_port_mode == 2'b10);

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> (xrd_n && xwr_n && !pd_oe)); // R1

  AST_BCAST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n && !xwr_n) |-> (pd_oe && $past(cfg_sel))); // R2

  AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n && xwr_n) |-> (!pd_oe && host_rdata_oe && host_rdata == pd_in)); // R6

  AST_RELEASE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ior_n && host_iow_n && !cfg_sel) |=> (xrd_n && xwr_n)); // R9

  AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_aen && !cfg_sel) |=> (xrd_n && xwr_n)); // R9

  AST_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (xrd_n != xwr_n) |-> (xa == $past(host_addr[LOW_W-1:0]))); // R8

  AST_ROUTING: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on |-> (xtc == host_tc && host_irq7 == xirq && host_drq == xdrq)); // R10
endmodule

bind xb_bridge xb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (.*);

// File: tb/sim_xb_bridge.sv
module sim_xb_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ext_dis = 1'b0;
  logic [1:0] cfg_port_mode = 2'b10;
  logic       cfg_coarse = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [9:0] host_addr = '0;
  logic       host_aen = 1'b0;
  logic       host_ior_n = 1'b1;
  logic       host_iow_n = 1'b1;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rdata_oe;
  logic       host_tc = 1'b0;
  logic       host_irq7, host_drq;
  logic       xrd_n, xwr_n;
  logic [2:0] xa;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [7:0] pd_in = '0;
  logic       xirq = 1'b0;
  logic       xdrq = 1'b0;
  logic       xtc;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  xb_bridge u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bcast(input logic [7:0] b);
    @(negedge clk); cfg_sel = 1'b1; cfg_data = b;
    @(negedge clk);
    chk(!xrd_n && !xwr_n, "R2 strobes low", {xrd_n, xwr_n}, 0);
    chk(pd_oe && pd_out == b, "R2 byte on pins", {pd_oe, pd_out}, {1'b1, b});
    cfg_sel = 1'b0;
    @(negedge clk);
    chk(xrd_n && xwr_n, "R2 release", {xrd_n, xwr_n}, 3);
  endtask

  task automatic rd(input logic [9:0] a, input bit exp_hit, input string tag);
    logic [7:0] v;
    v = a[7:0] ^ 8'h5A;
    @(negedge clk); host_addr = a; host_ior_n = 1'b0; pd_in = v;
    @(negedge clk);
    chk(xrd_n == !exp_hit, tag, xrd_n, !exp_hit);
    if (exp_hit) begin
      chk(xwr_n && !pd_oe && host_rdata_oe && host_rdata == v && xa == a[2:0],
          "R6 R8 read data", {host_rdata, 5'b0, xa}, {v, 5'b0, a[2:0]});
    end
    host_ior_n = 1'b1;
    @(negedge clk);
    chk(xrd_n, "R9 read release", xrd_n, 1);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d, input bit exp_hit);
    @(negedge clk); host_addr = a; host_iow_n = 1'b0; host_wdata = d;
    @(negedge clk);
    chk(xwr_n == !exp_hit && xrd_n, "R7 write strobe", {xrd_n, xwr_n}, {1'b1, !exp_hit});
    if (exp_hit)
      chk(pd_oe && pd_out == d && xa == a[2:0], "R7 R8 write data",
          {pd_out, 5'b0, xa}, {d, 5'b0, a[2:0]});
    host_iow_n = 1'b1;
    @(negedge clk);
    chk(xwr_n && !pd_oe, "R9 write release", {xwr_n, pd_oe}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] bases [5];
    bases = '{8'h00, 8'hFF, 8'h3C, 8'h9D, 8'h5E};
    repeat (3) @(negedge clk);
    chk(xrd_n && xwr_n && !pd_oe, "R1 reset state", {xrd_n, xwr_n, pd_oe}, 6);
    rst_n = 1'b1;
    // R3: reset base (0) must not match address 0 until written
    rd(10'h000, 1'b0, "R3 no cycle before base written");
    rd(10'h004, 1'b0, "R3 no cycle before base written");

    // R4 / R5 sweeps
    for (int c = 0; c < 2; c++) begin
      cfg_coarse = c[0];
      for (int b = 0; b < 5; b++) begin
        bcast(bases[b]);
        for (int a = 0; a < 1024; a++) begin
          bit h;
          h = c[0] ? ((a >> 4) == (bases[b] >> 2)) : ((a >> 3) == (bases[b] >> 1));
          rd(a[9:0], h, c[0] ? "R5 coarse decode" : "R4 fine decode");
        end
      end
    end

    // writes, fine window at base byte 8'h3C -> 0x0F0..0x0F7
    cfg_coarse = 1'b0;
    bcast(8'h3C);
    wr(10'h0F0, 8'hA5, 1'b1);
    wr(10'h0F7, 8'h3C, 1'b1);
    wr(10'h0F8, 8'h11, 1'b0);
    wr(10'h0EF, 8'h22, 1'b0);

    // R9: AEN high blocks the cycle
    @(negedge clk); host_aen = 1'b1; host_addr = 10'h0F2; host_ior_n = 1'b0;
    @(negedge clk);
    chk(xrd_n, "R9 aen blocks", xrd_n, 1);
    host_ior_n = 1'b1; host_aen = 1'b0;
    @(negedge clk);

    // R9: strobe holds for a long command
    @(negedge clk); host_addr = 10'h0F3; host_ior_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!xrd_n, "R9 strobe held", xrd_n, 0);
    end
    host_ior_n = 1'b1;
    @(negedge clk);
    chk(xrd_n, "R9 strobe released", xrd_n, 1);

    // R11: config write beats an overlapping adapter write
    @(negedge clk); host_addr = 10'h0F1; host_iow_n = 1'b0; host_wdata = 8'h77;
    cfg_sel = 1'b1; cfg_data = 8'h3C;
    @(negedge clk);
    chk(!xrd_n && !xwr_n && pd_out == 8'h3C, "R11 config priority", {xrd_n, xwr_n, pd_out}, 8'h3C);
    cfg_sel = 1'b0; host_iow_n = 1'b1;
    @(negedge clk);

    // R1 / R10: every configuration combination
    for (int m = 0; m < 8; m++) begin
      bit act;
      act = (m == 2);
      @(negedge clk); cfg_ext_dis = m[2]; cfg_port_mode = m[1:0];
      xirq = 1'b1; xdrq = 1'b1; host_tc = 1'b1;
      #1;
      chk({host_irq7, host_drq, xtc} == {3{act}}, "R10 R1 routing high", {host_irq7, host_drq, xtc}, {3{act}});
      xirq = 1'b0; xdrq = 1'b0; host_tc = 1'b0;
      #1;
      chk({host_irq7, host_drq, xtc} == 3'b000, "R10 routing low", {host_irq7, host_drq, xtc}, 0);
      rd(10'h0F5, act, "R1 mode gates read");
      wr(10'h0F6, 8'hC3, act);
    end
    cfg_ext_dis = 1'b0; cfg_port_mode = 2'b10;

    // R3: base held after gated period, and re-latchable
    rd(10'h0F4, 1'b1, "R3 base retained");
    bcast(8'h80);
    rd(10'h200, 1'b1, "R3 new base hit");
    rd(10'h0F4, 1'b0, "R3 old base miss");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule